// File: doc/BRIEF.md
# Saturating Complex Butterfly

This block performs one radix-2 butterfly step on complex samples. It takes two complex operands A and B and a complex twiddle W. Each real and imaginary part is an 8-bit signed two's-complement value. The block forms the product W·B at full precision, then rescales it with an arithmetic right shift of 7. It produces the sum X = A + W·B and the difference Y = A − W·B, one component at a time. Each of the four output components is clamped to the signed 8-bit range, so an overflow never wraps.

The twiddle is read as Q1.7 fixed point. In that format +1 is approximated by 127, and −1 is exactly −128. A parameter selects whether the results pass through a register stage, which gives one cycle of latency, or leave the block combinationally. A valid strobe travels with the data. Every output is a pure integer function of the inputs, so a software model can predict each bit.

Top module: `cbfly_sat`

## Requirements
- R1: With the registered stage enabled, during and right after reset `outValid` is 0 and xRe, xIm, yRe and yIm are all 0.
- R2: The scaled product is pRe = (wRe·bRe − wIm·bIm) >>> 7 and pIm = (wRe·bIm + wIm·bRe) >>> 7. Both are formed in at least 17-bit signed precision, and the shift is arithmetic (floor toward −infinity).
- R3: xRe = sat(aRe + pRe), xIm = sat(aIm + pIm), yRe = sat(aRe − pRe) and yIm = sat(aIm − pIm).
- R4: sat(v) gives 127 for v > 127, −128 for v < −128, and v otherwise. A sum or difference never wraps.
- R5: A twiddle of (127, 0), Q1.7 positive unity, gives pRe = (127·bRe) >>> 7 and pIm = (127·bIm) >>> 7.
- R6: A twiddle of (−128, 0) gives exactly pRe = −bRe and pIm = −bIm. When B = (−128, −128) the product is +128, and the outputs saturate.
- R7: A twiddle of (0, −128), which is −j, gives exactly pRe = bIm and pIm = −bRe. This is a 90-degree clockwise rotation.
- R8: With the registered stage enabled, the outputs and `outValid` reflect the inputs sampled at the previous rising clock edge when `inValid` was 1. A cycle with `inValid` at 0 leaves all four outputs unchanged and drives `outValid` to 0 one cycle later.
- R9: With the registered stage disabled, the outputs follow the inputs in the same cycle, and `outValid` equals `inValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands on the inputs are valid |
| aRe | input | 8 | Operand A, real part (signed) |
| aIm | input | 8 | Operand A, imaginary part (signed) |
| bRe | input | 8 | Operand B, real part (signed) |
| bIm | input | 8 | Operand B, imaginary part (signed) |
| wRe | input | 8 | Twiddle, real part (signed Q1.7) |
| wIm | input | 8 | Twiddle, imaginary part (signed Q1.7) |
| outValid | output | 1 | Results on the outputs are valid |
| xRe | output | 8 | Sum output, real part (saturated) |
| xIm | output | 8 | Sum output, imaginary part (saturated) |
| yRe | output | 8 | Difference output, real part (saturated) |
| yIm | output | 8 | Difference output, imaginary part (saturated) |

## Verification
The bench builds two copies with the default widths: 8-bit data, 8-bit twiddle and a shift of 7. One copy has the registered stage enabled (`OUT_REG=1`) and the other has it disabled (`OUT_REG=0`), and both are driven with the same operands. The registered copy brings the reset values, the one-cycle latency and output holding when `inValid` is 0 within reach. The combinational copy shows that the same arithmetic appears in the same cycle. Between them they are exercised with unity, negative-unity and −j twiddles, with rail-hitting operands that force each output component into positive and negative saturation, and with pseudo-random operands checked against an integer model.

// File: rtl/cbfly_pkg.sv
package cbfly_pkg;

  typedef struct packed {
    logic load;   // capture new results into the output stage
    logic drop;   // cycle without valid operands
  } strobe_t;

endpackage

// File: rtl/cbfly_ctrl.sv
module cbfly_ctrl
  import cbfly_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  output strobe_t strb,
  output logic    outValid
);

  always_comb begin
    strb.load = inValid;
    strb.drop = ~inValid;
  end

  generate
    if (OUT_REG) begin : g_reg
      logic vldQ;
      always_ff @(posedge clk) begin
        if (!rstN) vldQ <= 1'b0;
        else       vldQ <= inValid;
      end
      assign outValid = vldQ;

      AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
        inValid |=> outValid);                                       // R8
      AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> !outValid);                                     // R8
    end else begin : g_comb
      assign outValid = inValid;
    end
  endgenerate

endmodule

// File: rtl/cbfly_cmul.sv
module cbfly_cmul #(
  parameter int DATA_W = 8,
  parameter int TW_W   = 8,
  parameter int SHIFT  = 7,
  parameter int PROD_W = DATA_W + TW_W + 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic signed [DATA_W-1:0] bRe,
  input  logic signed [DATA_W-1:0] bIm,
  input  logic signed [TW_W-1:0]   wRe,
  input  logic signed [TW_W-1:0]   wIm,
  output logic signed [PROD_W-1:0] pRe,
  output logic signed [PROD_W-1:0] pIm
);

  localparam int MW = DATA_W + TW_W;
  localparam logic signed [TW_W-1:0] TW_MIN = {1'b1, {(TW_W-1){1'b0}}};

  logic signed [MW-1:0]     mRr, mIi, mRi, mIr;
  logic signed [PROD_W-1:0] rawRe, rawIm;

  always_comb begin
    mRr   = wRe * bRe;
    mIi   = wIm * bIm;
    mRi   = wRe * bIm;
    mIr   = wIm * bRe;
    rawRe = PROD_W'(mRr) - PROD_W'(mIi);
    rawIm = PROD_W'(mRi) + PROD_W'(mIr);
    pRe   = rawRe >>> SHIFT;
    pIm   = rawIm >>> SHIFT;
  end

  AST_NEG_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (wRe == TW_MIN && wIm == '0) |-> (pRe == -PROD_W'(bRe) && pIm == -PROD_W'(bIm)));  // R6
  AST_MINUS_J: assert property (@(posedge clk) disable iff (!rstN)
    (wRe == '0 && wIm == TW_MIN) |-> (pRe == PROD_W'(bIm) && pIm == -PROD_W'(bRe)));   // R7

endmodule

// File: rtl/cbfly_dp.sv
module cbfly_dp
  import cbfly_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int PROD_W  = 17,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strb,
  input  logic signed [DATA_W-1:0] aRe,
  input  logic signed [DATA_W-1:0] aIm,
  input  logic signed [PROD_W-1:0] pRe,
  input  logic signed [PROD_W-1:0] pIm,
  output logic signed [DATA_W-1:0] xRe,
  output logic signed [DATA_W-1:0] xIm,
  output logic signed [DATA_W-1:0] yRe,
  output logic signed [DATA_W-1:0] yIm
);

  localparam int LANES = 4;
  localparam int SW    = PROD_W + 1;
  localparam logic signed [SW-1:0] WMAX = SW'(2 ** (DATA_W - 1) - 1);
  localparam logic signed [SW-1:0] WMIN = -SW'(2 ** (DATA_W - 1));
  localparam logic signed [DATA_W-1:0] DMAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] DMIN = {1'b1, {(DATA_W-1){1'b0}}};

  // lane order: 0 xRe, 1 xIm, 2 yRe, 3 yIm
  logic signed [SW-1:0]     wide [LANES];
  logic signed [DATA_W-1:0] satV [LANES];
  logic signed [DATA_W-1:0] outV [LANES];

  always_comb begin
    wide[0] = SW'(aRe) + SW'(pRe);
    wide[1] = SW'(aIm) + SW'(pIm);
    wide[2] = SW'(aRe) - SW'(pRe);
    wide[3] = SW'(aIm) - SW'(pIm);
  end

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_comb begin
        if (wide[g] > WMAX)      satV[g] = DMAX;
        else if (wide[g] < WMIN) satV[g] = DMIN;
        else                     satV[g] = DATA_W'(wide[g]);
      end

      if (OUT_REG) begin : g_reg
        logic signed [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
          if (!rstN)          q <= '0;
          else if (strb.load) q <= satV[g];
        end
        assign outV[g] = q;

        AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
          strb.drop |=> $stable(outV[g]));                           // R8
      end else begin : g_comb
        assign outV[g] = satV[g];
      end

      AST_NO_WRAP_HI: assert property (@(posedge clk) disable iff (!rstN)
        (wide[g] > WMAX) |-> (satV[g] == DMAX));                     // R4
      AST_NO_WRAP_LO: assert property (@(posedge clk) disable iff (!rstN)
        (wide[g] < WMIN) |-> (satV[g] == DMIN));                     // R4
    end
  endgenerate

  assign xRe = outV[0];
  assign xIm = outV[1];
  assign yRe = outV[2];
  assign yIm = outV[3];

  AST_SUM_DIFF_RE: assert property (@(posedge clk) disable iff (!rstN)
    (satV[0] != DMAX && satV[0] != DMIN && satV[2] != DMAX && satV[2] != DMIN)
    |-> ((SW'(satV[0]) + SW'(satV[2])) == (SW'(aRe) <<< 1)));        // R3
  AST_SUM_DIFF_IM: assert property (@(posedge clk) disable iff (!rstN)
    (satV[1] != DMAX && satV[1] != DMIN && satV[3] != DMAX && satV[3] != DMIN)
    |-> ((SW'(satV[1]) + SW'(satV[3])) == (SW'(aIm) <<< 1)));        // R3

endmodule

// File: rtl/cbfly_sat.sv
module cbfly_sat
  import cbfly_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int TW_W    = 8,
  parameter int SHIFT   = 7,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] aRe,
  input  logic signed [DATA_W-1:0] aIm,
  input  logic signed [DATA_W-1:0] bRe,
  input  logic signed [DATA_W-1:0] bIm,
  input  logic signed [TW_W-1:0]   wRe,
  input  logic signed [TW_W-1:0]   wIm,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] xRe,
  output logic signed [DATA_W-1:0] xIm,
  output logic signed [DATA_W-1:0] yRe,
  output logic signed [DATA_W-1:0] yIm
);

  localparam int PROD_W = DATA_W + TW_W + 1;

  strobe_t                  strb;
  logic signed [PROD_W-1:0] pRe, pIm;

  cbfly_ctrl #(.OUT_REG(OUT_REG)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .strb(strb), .outValid(outValid)
  );

  cbfly_cmul #(.DATA_W(DATA_W), .TW_W(TW_W), .SHIFT(SHIFT), .PROD_W(PROD_W)) u_cmul (
    .clk(clk), .rstN(rstN), .bRe(bRe), .bIm(bIm), .wRe(wRe), .wIm(wIm),
    .pRe(pRe), .pIm(pIm)
  );

  cbfly_dp #(.DATA_W(DATA_W), .PROD_W(PROD_W), .OUT_REG(OUT_REG)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .aRe(aRe), .aIm(aIm),
    .pRe(pRe), .pIm(pIm), .xRe(xRe), .xIm(xIm), .yRe(yRe), .yIm(yIm)
  );

endmodule

// File: tb/cbfly_sat_test.sv
module cbfly_sat_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic signed [7:0] aRe = '0, aIm = '0, bRe = '0, bIm = '0, wRe = '0, wIm = '0;
  logic outValid, cValid;
  logic signed [7:0] xRe, xIm, yRe, yIm;
  logic signed [7:0] cxRe, cxIm, cyRe, cyIm;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int ex [4];

  always #2.5 clk = ~clk;

  cbfly_sat #(.OUT_REG(1'b1)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .aRe(aRe), .aIm(aIm), .bRe(bRe), .bIm(bIm), .wRe(wRe), .wIm(wIm),
    .outValid(outValid), .xRe(xRe), .xIm(xIm), .yRe(yRe), .yIm(yIm)
  );

  cbfly_sat #(.OUT_REG(1'b0)) uutComb (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .aRe(aRe), .aIm(aIm), .bRe(bRe), .bIm(bIm), .wRe(wRe), .wIm(wIm),
    .outValid(cValid), .xRe(cxRe), .xIm(cxIm), .yRe(cyRe), .yIm(cyIm)
  );

  function automatic int sat8(int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  // independent integer model of R2..R4
  task automatic model(input int ar, ai, br, bi, wr, wi);
    int pr, pi;
    pr = (wr * br - wi * bi) >>> 7;
    pi = (wr * bi + wi * br) >>> 7;
    ex[0] = sat8(ar + pr);
    ex[1] = sat8(ai + pi);
    ex[2] = sat8(ar - pr);
    ex[3] = sat8(ai - pi);
  endtask

  task automatic chk(input string req, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  task automatic chkRes(input string req, input int v, input int vc);
    chk(req, "reg xRe", int'(xRe), ex[0]);
    chk(req, "reg xIm", int'(xIm), ex[1]);
    chk(req, "reg yRe", int'(yRe), ex[2]);
    chk(req, "reg yIm", int'(yIm), ex[3]);
    chk(req, "reg outValid", int'(outValid), v);
    if (vc >= 0) chk(req, "comb outValid", int'(cValid), vc);
  endtask

  task automatic chkComb(input string req);
    chk(req, "comb xRe", int'(cxRe), ex[0]);
    chk(req, "comb xIm", int'(cxIm), ex[1]);
    chk(req, "comb yRe", int'(cyRe), ex[2]);
    chk(req, "comb yIm", int'(cyIm), ex[3]);
  endtask

  // drive at negedge, check comb copy, then registered copy one edge later
  task automatic run(input string req, input int ar, ai, br, bi, wr, wi);
    @(negedge clk);
    aRe = 8'(ar); aIm = 8'(ai); bRe = 8'(br); bIm = 8'(bi);
    wRe = 8'(wr); wIm = 8'(wi); inValid = 1'b1;
    model(ar, ai, br, bi, wr, wi);
    #1;
    chkComb(req);
    chk("R9", "comb outValid", int'(cValid), 1);
    @(posedge clk);
    #1;
    chkRes(req, 1, -1);
  endtask

  task automatic tReset();
    ex = '{0, 0, 0, 0};
    chkRes("R1", 0, -1);
  endtask

  task automatic tPlain();
    run("R3", 10, -20, 30, 40, 127, 0);
    run("R2", 5, 7, -3, 9, 64, -64);
    run("R2", 0, 0, -1, 1, 1, 1);
  endtask

  task automatic tUnity();
    run("R5", 0, 0, 64, -64, 127, 0);
    run("R5", 3, -3, 127, -128, 127, 0);
  endtask

  task automatic tNegOne();
    run("R6", 20, -30, 50, -70, -128, 0);
    run("R6", 100, -100, -128, -128, -128, 0);
  endtask

  task automatic tNegJ();
    run("R7", 1, 2, 40, -90, 0, -128);
    run("R7", -100, 100, -128, 127, 0, -128);
  endtask

  task automatic tSaturate();
    run("R4", 127, 127, 127, 127, 127, 0);
    run("R4", -128, -128, 127, 127, 127, 0);
    run("R4", 120, -120, 100, -100, 90, 90);
  endtask

  task automatic tHold();
    // ex still holds the last applied result
    @(negedge clk);
    inValid = 1'b0;
    aRe = 8'sd77; bRe = -8'sd5; wRe = 8'sd33; wIm = -8'sd44;
    #1;
    chk("R9", "comb outValid idle", int'(cValid), 0);
    @(posedge clk);
    #1;
    chkRes("R8", 0, 0);
    @(posedge clk);
    #1;
    chkRes("R8", 0, 0);
  endtask

  task automatic tRandom();
    for (int i = 0; i < 40; i++) begin
      int v [6];
      for (int k = 0; k < 6; k++) v[k] = int'($urandom_range(255)) - 128;
      run("R3", v[0], v[1], v[2], v[3], v[4], v[5]);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    tReset();
    @(negedge clk);
    rstN = 1'b1;
    #1;
    tReset();
    tPlain();
    tUnity();
    tNegOne();
    tNegJ();
    tSaturate();
    tHold();
    tRandom();
    tHold();
    finishRun();
  end

endmodule